// File: doc/BRIEF.md
# Stereo Serial Audio Transmitter

This block takes one left and one right 24-bit two's-complement sample per audio frame and sends them most significant bit first on a single serial data line. The bit clock and the word-select (left/right) clock can be made inside the block, or they can come from another device. Two framings are available on a format input: the standard I2S framing, which delays each word by one bit clock after the word-select change, and a left-justified framing, which has no delay. When the block receives its clocks from outside, a frame may hold 48 or 64 bit clocks.

The role is set by a strap on the data pin. While reset is held and for the first clock after it, the block leaves the data pin undriven and reads it. A pull-up there makes the block the clock source, and a pull-down makes it follow external clocks. All logic runs on one fast system clock. The external bit clock and word-select are resynchronised and edge-detected on that clock. A producer offers a new sample pair with a one-cycle valid strobe. The block applies the pair at the next left-channel start and sends it again in every frame until a new pair arrives.

Top module: `stereo_ser_tx`

## Requirements
- R1: In the first system clock after reset is released, the block reads `sd_pad_in`. A 1 sets `is_master` and a 0 clears it. `sd_oe` and `clk_oe` are 0 during reset. They rise only after that read, and `is_master` does not change again until the next reset.
- R2: When the block is the clock source, `sclk_out` runs with a period of 2·SCLK_DIV system clocks. Each frame has MASTER_BITS bit clocks, with the left half first. `lrck_out` changes only in the system clock in which `sclk_out` falls, and `clk_oe` is 1.
- R3: The word-select level marks the channel. In I2S format (`fmt_i2s`=1), low means left. In left-justified format (`fmt_i2s`=0), high means left.
- R4: In left-justified format, bit 23 of a word goes out in the bit period that starts at the word-select change. Bits 22 down to 0 follow in the next 23 bit periods.
- R5: In I2S format, each word starts one bit period after the word-select change. The bit period at the change carries the last bit slot of the word before it.
- R6: Every bit period after bit 0 of a word, up to the next word, drives a 0.
- R7: `sd_out` changes only on a falling bit clock. As clock source, it changes in the same system clock as `sclk_out`. As follower, it changes no more than SYNC_STAGES+1 system clocks after `sclk_in` falls.
- R8: As follower with 48 bit clocks per frame, all 24 bits of both words arrive in both formats. In I2S, bit 0 of a word falls in the first bit period of the next half.
- R9: A pair offered with `smp_valid` is first sent starting at the next left-channel start. Both words of a frame come from the same pair, and the last pair is sent again while no new one arrives.
- R10: As follower, the block realigns to every word-select change. A change from 64 to 48 bit clocks per frame gives correct words from the first full frame after the change.
- R11: As follower, `clk_oe`, `sclk_out` and `lrck_out` stay 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, faster than four times the bit clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| fmt_i2s | input | 1 | 1: I2S framing, 0: left-justified framing |
| smp_valid | input | 1 | One-cycle strobe that offers a new sample pair |
| smp_left | input | SAMPLE_W | Left sample, two's complement |
| smp_right | input | SAMPLE_W | Right sample, two's complement |
| sclk_in | input | 1 | External bit clock, used as follower |
| lrck_in | input | 1 | External word-select, used as follower |
| sd_pad_in | input | 1 | Level read from the data pin, used as the role strap |
| sclk_out | output | 1 | Generated bit clock |
| lrck_out | output | 1 | Generated word-select |
| clk_oe | output | 1 | Drive enable for the two clock pins |
| sd_out | output | 1 | Serial data |
| sd_oe | output | 1 | Drive enable for the data pin |
| is_master | output | 1 | Role read from the strap |

## Verification
A shift register in the wrong state shows up at the data pin within one half-frame: bits slide by a position or leak into the zero padding. A wrong word-select tracking swaps channels, or an I2S word fails to start one bit late. A stale or early pair latch shows as a frame whose two words come from different pairs, visible within one frame of the strobe. A role latch that reads the pin while it is driven gives a master clock on a follower or silence on a source, within a few system clocks of reset.

// File: rtl/sat_pkg.sv
package sat_pkg;

  typedef enum logic {
    ROLE_SLAVE  = 1'b0,
    ROLE_MASTER = 1'b1
  } role_e;

  // Word-select level that marks a channel for a given framing.
  function automatic logic lr_level(input logic i2s, input logic left);
    return left ^ i2s;
  endfunction

  // True when a word-select level marks the left channel.
  function automatic logic lr_is_left(input logic i2s, input logic lrck);
    return lrck ^ i2s;
  endfunction

endpackage

// File: rtl/sat_strap.sv
module sat_strap (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pad_in,
  output logic          done,
  output sat_pkg::role_e role
);
  import sat_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      done <= 1'b0;
      role <= ROLE_SLAVE;
    end else if (!done) begin
      done <= 1'b1;
      role <= pad_in ? ROLE_MASTER : ROLE_SLAVE;
    end
  end
endmodule

// File: rtl/sat_mclk_gen.sv
module sat_mclk_gen #(
  parameter int FRAME_BITS = 64,
  parameter int SCLK_DIV   = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  input  logic fmt_i2s,
  output logic sclk,
  output logic lrck,
  output logic fall,
  output logic lrck_next
);
  import sat_pkg::*;

  localparam int DW   = (SCLK_DIV > 1) ? $clog2(SCLK_DIV) : 1;
  localparam int CW   = $clog2(FRAME_BITS);
  localparam int HALF = FRAME_BITS / 2;

  logic [DW-1:0] div_q;
  logic [CW-1:0] cnt_q;
  logic [CW-1:0] cnt_nx;
  logic          sclk_q;
  logic          lrck_q;
  logic          tick;

  assign tick      = en && (div_q == DW'(SCLK_DIV - 1));
  assign fall      = tick && sclk_q;
  assign cnt_nx    = (cnt_q == CW'(FRAME_BITS - 1)) ? '0 : cnt_q + 1'b1;
  assign lrck_next = lr_level(fmt_i2s, cnt_nx < CW'(HALF));
  assign sclk      = sclk_q;
  assign lrck      = lrck_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      div_q  <= '0;
      cnt_q  <= CW'(FRAME_BITS - 1);
      sclk_q <= 1'b0;
      lrck_q <= lr_level(fmt_i2s, 1'b0);
    end else if (!en) begin
      div_q  <= '0;
      cnt_q  <= CW'(FRAME_BITS - 1);
      sclk_q <= 1'b0;
      lrck_q <= lr_level(fmt_i2s, 1'b0);
    end else if (tick) begin
      div_q  <= '0;
      sclk_q <= ~sclk_q;
      if (sclk_q) begin
        cnt_q  <= cnt_nx;
        lrck_q <= lrck_next;
      end
    end else begin
      div_q <= div_q + 1'b1;
    end
  end
endmodule

// File: rtl/sat_slave_sync.sv
module sat_slave_sync #(
  parameter int SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sclk_in,
  input  logic lrck_in,
  output logic fall,
  output logic lrck_now
);
  logic [SYNC_STAGES:0]   sc_q;
  logic [SYNC_STAGES-1:0] lr_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sc_q <= '0;
    else        sc_q <= {sc_q[SYNC_STAGES-1:0], sclk_in};
  end

  generate
    if (SYNC_STAGES == 1) begin : g_lr_one
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lr_q <= '0;
        else        lr_q <= lrck_in;
      end
    end else begin : g_lr_chain
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) lr_q <= '0;
        else        lr_q <= {lr_q[SYNC_STAGES-2:0], lrck_in};
      end
    end
  endgenerate

  // Word-select is taken at the same depth as the newer bit-clock stage.
  assign fall     = sc_q[SYNC_STAGES] && !sc_q[SYNC_STAGES-1];
  assign lrck_now = lr_q[SYNC_STAGES-1];
endmodule

// File: rtl/sat_shifter.sv
module sat_shifter #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                en,
  input  logic                fmt_i2s,
  input  logic                fall,
  input  logic                lrck_new,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  output logic                sd,
  output logic                lr_edge,
  output logic                left_start,
  output logic [SLOT_W-1:0]   slot_cnt,
  output logic [SAMPLE_W-1:0] pend_l,
  output logic [SAMPLE_W-1:0] act_l
);
  import sat_pkg::*;

  logic                lrck_seen;
  logic [SAMPLE_W-1:0] pend_r;
  logic [SAMPLE_W-1:0] act_r;
  logic [SAMPLE_W-1:0] sh_q;
  logic [SAMPLE_W-1:0] word_sel;
  logic                step;

  assign step       = en && fall;
  assign lr_edge    = step && (lrck_new != lrck_seen);
  assign left_start = lr_edge && lr_is_left(fmt_i2s, lrck_new);
  assign word_sel   = left_start ? pend_l : act_r;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_l <= '0;
      pend_r <= '0;
    end else if (smp_valid) begin
      pend_l <= smp_left;
      pend_r <= smp_right;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_l <= '0;
      act_r <= '0;
    end else if (left_start) begin
      act_l <= pend_l;
      act_r <= pend_r;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      lrck_seen <= lr_level(fmt_i2s, 1'b0);
      sh_q      <= '0;
      sd        <= 1'b0;
      slot_cnt  <= '0;
    end else if (step) begin
      lrck_seen <= lrck_new;
      if (lr_edge) begin
        slot_cnt <= '0;
        if (fmt_i2s) begin
          sd   <= sh_q[SAMPLE_W-1];
          sh_q <= word_sel;
        end else begin
          sd   <= word_sel[SAMPLE_W-1];
          sh_q <= {word_sel[SAMPLE_W-2:0], 1'b0};
        end
      end else begin
        sd   <= sh_q[SAMPLE_W-1];
        sh_q <= {sh_q[SAMPLE_W-2:0], 1'b0};
        if (slot_cnt != '1) slot_cnt <= slot_cnt + 1'b1;
      end
    end
  end
endmodule

// File: rtl/stereo_ser_tx.sv
module stereo_ser_tx #(
  parameter int SAMPLE_W    = 24,
  parameter int MASTER_BITS = 64,
  parameter int SCLK_DIV    = 2,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                fmt_i2s,
  input  logic                smp_valid,
  input  logic [SAMPLE_W-1:0] smp_left,
  input  logic [SAMPLE_W-1:0] smp_right,
  input  logic                sclk_in,
  input  logic                lrck_in,
  input  logic                sd_pad_in,
  output logic                sclk_out,
  output logic                lrck_out,
  output logic                clk_oe,
  output logic                sd_out,
  output logic                sd_oe,
  output logic                is_master
);
  import sat_pkg::*;

  localparam int SLOT_W = $clog2(MASTER_BITS);

  role_e               role;
  logic                strap_done;
  logic                m_sclk, m_lrck, m_fall, m_lrck_nx;
  logic                s_fall, s_lrck;
  logic                fall_evt;
  logic                lrck_new;
  logic                lr_edge;
  logic                left_start;
  logic [SLOT_W-1:0]   slot_cnt;
  logic [SAMPLE_W-1:0] pend_l;
  logic [SAMPLE_W-1:0] act_l;

  sat_strap u_strap (
    .clk    (clk),
    .rst_n  (rst_n),
    .pad_in (sd_pad_in),
    .done   (strap_done),
    .role   (role)
  );

  assign is_master = (role == ROLE_MASTER);
  assign clk_oe    = strap_done && is_master;

  sat_mclk_gen #(.FRAME_BITS(MASTER_BITS), .SCLK_DIV(SCLK_DIV)) u_mclk (
    .clk       (clk),
    .rst_n     (rst_n),
    .en        (clk_oe),
    .fmt_i2s   (fmt_i2s),
    .sclk      (m_sclk),
    .lrck      (m_lrck),
    .fall      (m_fall),
    .lrck_next (m_lrck_nx)
  );

  sat_slave_sync #(.SYNC_STAGES(SYNC_STAGES)) u_sync (
    .clk      (clk),
    .rst_n    (rst_n),
    .sclk_in  (sclk_in),
    .lrck_in  (lrck_in),
    .fall     (s_fall),
    .lrck_now (s_lrck)
  );

  assign fall_evt = strap_done && (is_master ? m_fall : s_fall);
  assign lrck_new = is_master ? m_lrck_nx : s_lrck;

  sat_shifter #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_shift (
    .clk        (clk),
    .rst_n      (rst_n),
    .en         (strap_done),
    .fmt_i2s    (fmt_i2s),
    .fall       (fall_evt),
    .lrck_new   (lrck_new),
    .smp_valid  (smp_valid),
    .smp_left   (smp_left),
    .smp_right  (smp_right),
    .sd         (sd_out),
    .lr_edge    (lr_edge),
    .left_start (left_start),
    .slot_cnt   (slot_cnt),
    .pend_l     (pend_l),
    .act_l      (act_l)
  );

  assign sclk_out = m_sclk;
  assign lrck_out = clk_oe && m_lrck;
  assign sd_oe    = strap_done;
endmodule

// File: rtl/stereo_ser_tx_chk.sv
module stereo_ser_tx_chk #(
  parameter int SAMPLE_W = 24,
  parameter int SLOT_W   = 6
) (
  input logic                clk,
  input logic                rst_n,
  input logic                strap_done,
  input logic                is_master,
  input logic                clk_oe,
  input logic                sclk_out,
  input logic                lrck_out,
  input logic                sd_out,
  input logic                fall_evt,
  input logic                left_start,
  input logic [SLOT_W-1:0]   slot_cnt,
  input logic [SAMPLE_W-1:0] pend_l,
  input logic [SAMPLE_W-1:0] act_l
);
  // R1: role fixed once read
  p_role_locked_r1: assert property (@(posedge clk) disable iff (!rst_n)
    strap_done |=> $stable(is_master));

  // R2: generated word-select moves only with a falling bit clock
  p_lrck_on_fall_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (clk_oe && $past(clk_oe) && !$stable(lrck_out)) |-> $fell(sclk_out));

  // R6: slots past the word are zero
  p_pad_zero_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (strap_done && (slot_cnt > SLOT_W'(SAMPLE_W))) |-> !sd_out);

  // R7: data only moves after a falling-edge event
  p_sd_on_fall_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(fall_evt) |-> $stable(sd_out));

  // R9: pair applied at left start
  p_left_latch_r9: assert property (@(posedge clk) disable iff (!rst_n)
    left_start |=> (act_l == $past(pend_l)));

  // R11: no generated bit clock as follower
  p_clk_quiet_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !clk_oe |-> !sclk_out);
endmodule

bind stereo_ser_tx stereo_ser_tx_chk #(.SAMPLE_W(SAMPLE_W), .SLOT_W(SLOT_W)) u_chk (
  .clk        (clk),
  .rst_n      (rst_n),
  .strap_done (strap_done),
  .is_master  (is_master),
  .clk_oe     (clk_oe),
  .sclk_out   (sclk_out),
  .lrck_out   (lrck_out),
  .sd_out     (sd_out),
  .fall_evt   (fall_evt),
  .left_start (left_start),
  .slot_cnt   (slot_cnt),
  .pend_l     (pend_l),
  .act_l      (act_l)
);

// File: tb/stereo_ser_tx_test.sv
module stereo_ser_tx_test;
  localparam int CLK_PERIOD = 10;
  localparam int DIV        = 2;
  localparam int MBITS      = 64;
  localparam int MFRAME     = MBITS * 2 * DIV;
  localparam int SH         = 6;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        fmt_i2s = 1'b0;
  logic        smp_valid = 1'b0;
  logic [23:0] smp_left = '0, smp_right = '0;
  logic        sclk_in = 1'b1, lrck_in = 1'b0;
  logic        strap_pull = 1'b0;
  logic        sd_pad;
  logic        sclk_out, lrck_out, clk_oe, sd_out, sd_oe, is_master;

  assign sd_pad = sd_oe ? sd_out : strap_pull;

  always #(CLK_PERIOD/2) clk = ~clk;

  stereo_ser_tx #(.SAMPLE_W(24), .MASTER_BITS(MBITS), .SCLK_DIV(DIV), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst_n(rst_n), .fmt_i2s(fmt_i2s), .smp_valid(smp_valid),
    .smp_left(smp_left), .smp_right(smp_right), .sclk_in(sclk_in), .lrck_in(lrck_in),
    .sd_pad_in(sd_pad), .sclk_out(sclk_out), .lrck_out(lrck_out), .clk_oe(clk_oe),
    .sd_out(sd_out), .sd_oe(sd_oe), .is_master(is_master)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 1'b0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // ---------------- serial receiver model ----------------
  bit          mon_on = 0, mon_master = 0, mon_i2s = 0, mon_started = 0;
  logic        mon_sclk_q = 0, mon_lr_q = 0, mon_sd_q = 0, mon_lr_rise = 0, mon_mark = 0;
  logic [23:0] mon_acc = '0;
  int          mon_k = 0, fall_age = 0;
  int          pad_err = 0, pad_seen = 0, edge_err = 0, quiet_err = 0;
  int          rises_half = 0, half_len = 0, per_cnt = 0, per_last = 0;
  bit          cap_left [64];
  logic [23:0] cap_w [64];
  int          ncap = 0;

  always @(negedge clk) begin
    logic sc, lr, mark;
    sc = mon_master ? sclk_out : sclk_in;
    lr = mon_master ? lrck_out : lrck_in;
    if (mon_on) begin
      per_cnt++;
      if (sc && !mon_sclk_q) begin
        per_last = per_cnt;
        per_cnt = 0;
        rises_half++;
        mark = mon_i2s ? mon_lr_rise : lr;
        if (mark != mon_mark) begin
          if (mon_started && mon_k >= 24 && ncap < 64) begin
            cap_left[ncap] = (mon_mark == !mon_i2s);
            cap_w[ncap] = mon_acc;
            ncap++;
          end
          mon_started = 1;
          mon_k = 0;
          mon_acc = '0;
        end
        if (mon_k < 24) mon_acc[23 - mon_k] = sd_out;
        else if (mon_started) begin
          pad_seen++;
          if (sd_out) pad_err++;
        end
        mon_k++;
        mon_lr_rise = lr;
        mon_mark = mark;
      end
      if (mon_master) begin
        if (lr != mon_lr_q) begin
          half_len = rises_half;
          rises_half = 0;
          if (!(mon_sclk_q && !sc)) edge_err++;
        end
        if (sd_out != mon_sd_q && !(mon_sclk_q && !sc)) edge_err++;
      end else begin
        if (!sc && mon_sclk_q) fall_age = 0;
        else fall_age++;
        if (sd_out != mon_sd_q && fall_age > 3) edge_err++;
        if (clk_oe || sclk_out || lrck_out) quiet_err++;
      end
    end
    mon_sclk_q = sc;
    mon_lr_q = lr;
    mon_sd_q = sd_out;
  end

  task automatic mon_clear();
    @(negedge clk);
    mon_started = 0; ncap = 0; pad_err = 0; pad_seen = 0;
    edge_err = 0; quiet_err = 0; half_len = 0; rises_half = 0;
  endtask

  // ---------------- stimulus helpers ----------------
  task automatic do_reset(input bit strap, input bit i2s, input string tag);
    mon_on = 0;
    @(posedge clk); #1;
    rst_n = 0; fmt_i2s = i2s; strap_pull = strap;
    sclk_in = 1'b1; lrck_in = i2s;
    mon_master = strap; mon_i2s = i2s;
    repeat (4) @(posedge clk);
    @(negedge clk);
    chk(!sd_oe && !clk_oe, {tag, " R1 outputs undriven in reset"}, {sd_oe, clk_oe}, 0);
    @(posedge clk); #1;
    rst_n = 1;
    repeat (3) @(posedge clk);
    @(negedge clk);
    chk(is_master == strap && sd_oe, {tag, " R1 strap read"}, {is_master, sd_oe}, {strap, 1'b1});
    mon_on = 1;
  endtask

  task automatic put_pair(input logic [23:0] l, input logic [23:0] r);
    @(posedge clk); #1;
    smp_valid = 1; smp_left = l; smp_right = r;
    @(posedge clk); #1;
    smp_valid = 0; smp_left = '0; smp_right = '0;
  endtask

  task automatic slave_frames(input int nfr, input int bits, input bit i2s);
    for (int f = 0; f < nfr; f++) begin
      for (int s = 0; s < bits; s++) begin
        @(posedge clk); #1;
        sclk_in = 0;
        lrck_in = (s < bits/2) ? !i2s : i2s;
        repeat (SH) @(posedge clk);
        #1 sclk_in = 1;
        repeat (SH - 1) @(posedge clk);
      end
    end
  endtask

  task automatic chk_words(input logic [23:0] l, input logic [23:0] r, input string tag);
    int nl = 0, nr = 0, bl = 0, br = 0;
    logic [23:0] wl = '0, wr = '0;
    for (int i = 0; i < ncap; i++) begin
      if (cap_left[i]) begin
        nl++;
        if (cap_w[i] != l) begin bl++; wl = cap_w[i]; end
      end else begin
        nr++;
        if (cap_w[i] != r) begin br++; wr = cap_w[i]; end
      end
    end
    chk(nl >= 2 && nr >= 2, {tag, " words captured"}, nl + nr, 4);
    chk(bl == 0, {tag, " left word"}, bl ? wl : l, l);
    chk(br == 0, {tag, " right word"}, br ? wr : r, r);
  endtask

  // ---------------- scenarios ----------------
  task automatic t_master_lj();
    do_reset(1, 0, "master-LJ");
    put_pair(24'h80_0001, 24'h7F_FFFE);
    repeat (2 * MFRAME) @(posedge clk);
    mon_clear();
    repeat (3 * MFRAME) @(posedge clk);
    chk_words(24'h80_0001, 24'h7F_FFFE, "R4 R3 master LJ");
    chk(pad_err == 0 && pad_seen > 0, "R6 padding zero LJ", pad_err, 0);
    chk(edge_err == 0, "R7 R2 changes on falling only", edge_err, 0);
    chk(per_last == 2 * DIV, "R2 bit clock period", per_last, 2 * DIV);
    chk(half_len == MBITS / 2, "R2 bit clocks per half", half_len, MBITS / 2);
    chk(clk_oe, "R2 clock drive enable", clk_oe, 1);
  endtask

  task automatic t_master_i2s();
    do_reset(1, 1, "master-I2S");
    put_pair(24'hA5_C3E1, 24'h12_3456);
    repeat (2 * MFRAME) @(posedge clk);
    mon_clear();
    repeat (3 * MFRAME) @(posedge clk);
    chk_words(24'hA5_C3E1, 24'h12_3456, "R5 R3 master I2S");
    chk(pad_err == 0 && pad_seen > 0, "R6 padding zero I2S", pad_err, 0);
    chk(edge_err == 0, "R7 master I2S timing", edge_err, 0);
  endtask

  task automatic t_pairing();
    int j;
    int na;
    do_reset(1, 0, "pairing");
    put_pair(24'h11_1111, 24'h22_2222);
    repeat (2 * MFRAME) @(posedge clk);
    mon_clear();
    @(negedge clk);
    while (lrck_out != 1'b0) @(negedge clk);
    while (lrck_out != 1'b1) @(negedge clk);
    repeat (20) @(posedge clk);
    put_pair(24'h33_3333, 24'h44_4444);
    repeat (3 * MFRAME) @(posedge clk);
    j = -1; na = 0;
    for (int i = 0; i < ncap; i++) begin
      if (cap_w[i] == 24'h11_1111 || cap_w[i] == 24'h22_2222) na++;
      if (j < 0 && cap_w[i] == 24'h33_3333) j = i;
    end
    chk(j > 0 && j + 1 < ncap, "R9 new pair seen", j, 1);
    if (j > 0 && j + 1 < ncap) begin
      chk(cap_left[j] && !cap_left[j-1] && cap_w[j-1] == 24'h22_2222,
          "R9 right word of old frame kept", cap_w[j-1], 24'h22_2222);
      chk(!cap_left[j+1] && cap_w[j+1] == 24'h44_4444,
          "R9 new pair same frame", cap_w[j+1], 24'h44_4444);
    end
    chk(na >= 3, "R9 old pair repeated", na, 3);
  endtask

  task automatic t_slave_i2s_64();
    do_reset(0, 1, "slave-I2S");
    put_pair(24'hFE_DCBA, 24'h01_2345);
    slave_frames(2, 64, 1);
    mon_clear();
    slave_frames(3, 64, 1);
    chk_words(24'hFE_DCBA, 24'h01_2345, "R5 slave I2S 64");
    chk(pad_err == 0 && pad_seen > 0, "R6 slave padding", pad_err, 0);
    chk(edge_err == 0, "R7 slave data latency", edge_err, 0);
    chk(quiet_err == 0, "R11 clock pins idle", quiet_err, 0);
  endtask

  task automatic t_slave_lj_switch();
    do_reset(0, 0, "slave-LJ");
    put_pair(24'h5A_5A5A, 24'hC0_FFEE);
    slave_frames(2, 64, 0);
    mon_clear();
    slave_frames(3, 48, 0);
    chk_words(24'h5A_5A5A, 24'hC0_FFEE, "R10 R8 realign to 48 LJ");
    chk(edge_err == 0 && quiet_err == 0, "R11 R7 slave LJ", edge_err + quiet_err, 0);
  endtask

  task automatic t_slave_i2s_48();
    do_reset(0, 1, "slave-I2S48");
    put_pair(24'h80_0000, 24'h00_0001);
    slave_frames(2, 48, 1);
    mon_clear();
    slave_frames(3, 48, 1);
    chk_words(24'h80_0000, 24'h00_0001, "R8 slave I2S 48 bit 0 carried");
  endtask

  initial begin
    t_master_lj();
    t_master_i2s();
    t_pairing();
    t_slave_i2s_64();
    t_slave_lj_switch();
    t_slave_i2s_48();
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end
endmodule